// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM with Shared Data Path

This block is a synthesizable model of a synchronous static memory that moves two data beats per access, one in each half of the interface clock. A single clock runs at twice the interface rate, and the phase input `k_rise` marks each edge as either the rising edge of the interface clock (the "K slot") or the rising edge of its complement (the "K-bar slot"). Commands, addresses and the first data beat belong to K slots. The second data beat belongs to the K-bar slot that follows.

Writes use a late-data scheme. The address is given with the command, and the data follows one full interface cycle later. The data waits in a one-entry write buffer and is written to the array on the next K slot. Reads look up both the array and this buffer, so a read always sees the most recent write, merged byte by byte. Read data leaves through a registered output stage one and a half interface cycles after the command. The shared pad bus is modelled as a separate input bus, an output bus and an output-enable.

Top module: `ddr2b_sram`

## Requirements
- R1: Commands are taken only on K slots (`k_rise`=1). `rd_n` and `wr_n` on K-bar slots have no effect. `k_rise` alternates 1,0,1,0 and is 1 on the first slot after reset.
- R2: A read taken on edge t (`rd_n`=0, `wr_n`=1) registers its first beat on edge t+3, a K-bar slot, and its second beat on edge t+4. A read may be issued on every K slot, which gives a continuous stream of beats.
- R3: A write taken on K edge t takes its first beat from `dq_i`/`bw_n` on edge t+2 and its second beat on edge t+3. The array is updated on edge t+4.
- R4: Bit i of `bw_n`, when low, enables byte lane i (bits 8i+7..8i) for that beat only. The two beats of one write carry independent masks.
- R5: `addr[0]` is ignored. The first beat is the even word {row,0} and the second beat is the odd word {row,1}, with row = `addr[ADDR_W-1:1]`.
- R6: A read returns the merged result of every earlier write. This includes a write whose data is still in the buffer, such as a write issued on the K slot just before the read.
- R7: On a K slot where `rd_n` and `wr_n` are both low, neither a read nor a write takes place.
- R8: `dq_oe` and `q_valid` are high only during the two beat slots of a read. In every other slot they are low and `dq_o` is zero.
- R9: A synchronous active-high `rst` clears the outputs, drops pending reads and empties the write buffer. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each edge is one half-cycle slot |
| rst | input | 1 | Synchronous active-high reset |
| k_rise | input | 1 | 1 on K slots, 0 on K-bar slots |
| addr | input | ADDR_W | Word address; the low bit is ignored |
| rd_n | input | 1 | Active-low read command |
| wr_n | input | 1 | Active-low write command |
| bw_n | input | DATA_W/8 | Active-low byte write enables for the current beat |
| dq_i | input | DATA_W | Write data beat from the pad |
| dq_o | output | DATA_W | Read data beat to the pad |
| dq_oe | output | 1 | Pad output enable |
| q_valid | output | 1 | Marks each driven read beat |

## Verification
The hardest case to reach is a read whose row matches a write that has not yet reached the array. In that case some lanes must come from the buffer and others from the array, and the two beats use different masks. The stimulus reaches this case by issuing a partially masked write and then a read of the same row on the next K slot, so the merge stage sees the buffer full and the array still unwritten. It also places a write to a different row between the two, so that the first write is read back from the array instead. Resets that land between a command and its data or beats check that in-flight work is dropped.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
  localparam int BEATS  = 2;
  localparam int LANE_W = 8;
  localparam int RD_LAT = 4;   // read pipeline slots, command to second beat
  typedef enum logic {SLOT_KBAR = 1'b0, SLOT_K = 1'b1} slot_e;
endpackage

// File: rtl/ddr2b_cmd.sv
module ddr2b_cmd
  import ddr2b_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int ROW_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              k_rise,
  input  logic [ROW_W-1:0]  row,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              wa_vld,
  output logic [ROW_W-1:0]  wa_row,
  output logic [ROW_W-1:0]  rd_row,
  output logic [RD_LAT-1:0] rd_stage
);
  slot_e slot;
  logic  rd_go, wr_go;

  assign slot  = slot_e'(k_rise);
  // conflicting commands are dropped; K-bar slots never carry a command
  assign rd_go = (slot == SLOT_K) && !rd_n && wr_n;
  assign wr_go = (slot == SLOT_K) && !wr_n && rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wa_vld   <= 1'b0;
      wa_row   <= '0;
      rd_row   <= '0;
      rd_stage <= '0;
    end else begin
      rd_stage <= {rd_stage[RD_LAT-2:0], rd_go};
      if (slot == SLOT_K) begin
        wa_vld <= wr_go;
        if (wr_go) wa_row <= row;
      end
      if (rd_go) rd_row <= row;
    end
  end

  // R1: the phase flag must alternate every slot
  p_slot_alt_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (k_rise != $past(k_rise)));

  // R7: a clashing command starts nothing
  p_clash_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (k_rise && !rd_n && !wr_n) |=> (!rd_stage[0] && !wa_vld));
endmodule

// File: rtl/ddr2b_wbuf.sv
module ddr2b_wbuf
  import ddr2b_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 5,
  parameter int NB     = DATA_W / LANE_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         k_rise,
  input  logic                         wa_vld,
  input  logic [ROW_W-1:0]             wa_row,
  input  logic [DATA_W-1:0]            dq_i,
  input  logic [NB-1:0]                bw_n,
  output logic                         buf_vld,
  output logic [ROW_W-1:0]             buf_row,
  output logic [BEATS-1:0][DATA_W-1:0] buf_d,
  output logic [BEATS-1:0][NB-1:0]     buf_m,
  output logic                         cm_en
);
  // the buffer is drained on the K slot after its second beat arrives
  assign cm_en = k_rise && buf_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_vld <= 1'b0;
      buf_row <= '0;
      buf_d   <= '0;
      buf_m   <= '1;
    end else if (k_rise) begin
      buf_vld <= wa_vld;
      if (wa_vld) begin
        buf_row  <= wa_row;
        buf_d[0] <= dq_i;
        buf_m[0] <= bw_n;
        buf_m[1] <= '1;
      end
    end else if (buf_vld) begin
      buf_d[1] <= dq_i;
      buf_m[1] <= bw_n;
    end
  end

  // R3: an entry survives the K-bar slot that completes it
  p_hold_kbar_r3: assert property (@(posedge clk) disable iff (rst)
    (buf_vld && !k_rise) |=> buf_vld);
endmodule

// File: rtl/ddr2b_array.sv
module ddr2b_array
  import ddr2b_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 5,
  parameter int NB     = DATA_W / LANE_W
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [ROW_W-1:0]             wrow,
  input  logic [BEATS-1:0][DATA_W-1:0] wd,
  input  logic [BEATS-1:0][NB-1:0]     wm,
  input  logic                         re,
  input  logic [ROW_W-1:0]             rrow,
  output logic [BEATS-1:0][DATA_W-1:0] rq
);
  localparam int ROWS = 1 << ROW_W;

  for (genvar gb = 0; gb < BEATS; gb++) begin : g_beat
    for (genvar gl = 0; gl < NB; gl++) begin : g_lane
      logic [LANE_W-1:0] mem [ROWS];
      logic [LANE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
        if (we && !wm[gb][gl]) mem[wrow] <= wd[gb][gl*LANE_W +: LANE_W];
        if (re) lane_q <= mem[rrow];
      end

      assign rq[gb][gl*LANE_W +: LANE_W] = lane_q;
    end
  end
endmodule

// File: rtl/ddr2b_rdpath.sv
module ddr2b_rdpath
  import ddr2b_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 5,
  parameter int NB     = DATA_W / LANE_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [RD_LAT-1:0]            rd_stage,
  input  logic [ROW_W-1:0]             rd_row,
  input  logic [BEATS-1:0][DATA_W-1:0] rq,
  input  logic                         buf_vld,
  input  logic [ROW_W-1:0]             buf_row,
  input  logic [BEATS-1:0][DATA_W-1:0] buf_d,
  input  logic [BEATS-1:0][NB-1:0]     buf_m,
  output logic [DATA_W-1:0]            dq_o,
  output logic                         dq_oe,
  output logic                         q_valid
);
  logic                         hit;
  logic [BEATS-1:0][DATA_W-1:0] mrg_n, mrg_q;

  // lanes still sitting in the write buffer override the array copy
  always_comb begin
    hit = buf_vld && (buf_row == rd_row);
    for (int b = 0; b < BEATS; b++) begin
      for (int l = 0; l < NB; l++) begin
        mrg_n[b][l*LANE_W +: LANE_W] = (hit && !buf_m[b][l]) ?
          buf_d[b][l*LANE_W +: LANE_W] : rq[b][l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mrg_q <= '0;
    else if (rd_stage[1]) mrg_q <= mrg_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_o    <= '0;
      dq_oe   <= 1'b0;
      q_valid <= 1'b0;
    end else if (rd_stage[2]) begin
      dq_o    <= mrg_q[0];
      dq_oe   <= 1'b1;
      q_valid <= 1'b1;
    end else if (rd_stage[3]) begin
      dq_o    <= mrg_q[1];
      dq_oe   <= 1'b1;
      q_valid <= 1'b1;
    end else begin
      dq_o    <= '0;
      dq_oe   <= 1'b0;
      q_valid <= 1'b0;
    end
  end

  // R2: the bus is never driven for a single lone beat
  p_pair_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |=> dq_oe);
endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
  import ddr2b_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     k_rise,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic [DATA_W/LANE_W-1:0] bw_n,
  input  logic [DATA_W-1:0]        dq_i,
  output logic [DATA_W-1:0]        dq_o,
  output logic                     dq_oe,
  output logic                     q_valid
);
  localparam int NB    = DATA_W / LANE_W;
  localparam int ROW_W = ADDR_W - 1;

  logic                         addr_lsb_unused;
  logic                         wa_vld, buf_vld, cm_en;
  logic [ROW_W-1:0]             wa_row, rd_row, buf_row;
  logic [RD_LAT-1:0]            rd_stage;
  logic [BEATS-1:0][DATA_W-1:0] buf_d, rq;
  logic [BEATS-1:0][NB-1:0]     buf_m;

  assign addr_lsb_unused = addr[0];

  ddr2b_cmd #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_cmd (
    .clk(clk), .rst(rst), .k_rise(k_rise), .row(addr[ADDR_W-1:1]),
    .rd_n(rd_n), .wr_n(wr_n), .wa_vld(wa_vld), .wa_row(wa_row),
    .rd_row(rd_row), .rd_stage(rd_stage));

  ddr2b_wbuf #(.DATA_W(DATA_W), .ROW_W(ROW_W), .NB(NB)) u_wbuf (
    .clk(clk), .rst(rst), .k_rise(k_rise), .wa_vld(wa_vld), .wa_row(wa_row),
    .dq_i(dq_i), .bw_n(bw_n), .buf_vld(buf_vld), .buf_row(buf_row),
    .buf_d(buf_d), .buf_m(buf_m), .cm_en(cm_en));

  ddr2b_array #(.DATA_W(DATA_W), .ROW_W(ROW_W), .NB(NB)) u_array (
    .clk(clk), .we(cm_en), .wrow(buf_row), .wd(buf_d), .wm(buf_m),
    .re(rd_stage[0]), .rrow(rd_row), .rq(rq));

  ddr2b_rdpath #(.DATA_W(DATA_W), .ROW_W(ROW_W), .NB(NB)) u_rdpath (
    .clk(clk), .rst(rst), .rd_stage(rd_stage), .rd_row(rd_row), .rq(rq),
    .buf_vld(buf_vld), .buf_row(buf_row), .buf_d(buf_d), .buf_m(buf_m),
    .dq_o(dq_o), .dq_oe(dq_oe), .q_valid(q_valid));

  // port-level timing checks; the counter keeps $past inside the post-reset window
  logic       rd_cmd, wr_cmd;
  logic [2:0] chk_warm;
  assign rd_cmd = k_rise && !rd_n && wr_n;
  assign wr_cmd = k_rise && !wr_n && rd_n;

  always_ff @(posedge clk) begin
    if (rst) chk_warm <= '0;
    else if (chk_warm != 3'd5) chk_warm <= chk_warm + 3'd1;
  end

  p_beat0_r2: assert property (@(posedge clk) disable iff (rst)
    (chk_warm >= 3'd4 && $past(rd_cmd, 4)) |-> (dq_oe && q_valid));

  p_beat1_r2: assert property (@(posedge clk) disable iff (rst)
    (chk_warm == 3'd5 && $past(rd_cmd, 5)) |-> (dq_oe && q_valid));

  p_quiet_bus_r8: assert property (@(posedge clk) disable iff (rst)
    (chk_warm == 3'd5 && !$past(rd_cmd, 4) && !$past(rd_cmd, 5))
      |-> (!dq_oe && !q_valid && dq_o == '0));

  p_commit_r3: assert property (@(posedge clk) disable iff (rst)
    (chk_warm >= 3'd4 && $past(wr_cmd, 4)) |-> cm_en);

  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dq_oe && !q_valid));
endmodule

// File: tb/ddr2b_sram_bench.sv
module ddr2b_sram_bench;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NB = DW / 8;
  localparam int NS = 2048;

  // {addr[5:0], beat0[15:0], beat1[15:0], mask0[1:0], mask1[1:0]}
  localparam logic [41:0] VEC [0:7] = '{
    {6'd4,  16'hA1B2, 16'hC3D4, 2'b00, 2'b00},
    {6'd5,  16'h1111, 16'h2222, 2'b01, 2'b10},
    {6'd9,  16'h3333, 16'h4444, 2'b11, 2'b00},
    {6'd62, 16'h5566, 16'h7788, 2'b10, 2'b11},
    {6'd0,  16'h99AA, 16'hBBCC, 2'b00, 2'b01},
    {6'd33, 16'hDEAD, 16'hBEEF, 2'b01, 2'b01},
    {6'd4,  16'h0F0F, 16'hF0F0, 2'b01, 2'b10},
    {6'd17, 16'h1234, 16'h5678, 2'b11, 2'b11}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          k_rise = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          rd_n = 1'b1, wr_n = 1'b1;
  logic [NB-1:0] bw_n = '1;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe, q_valid;

  int total = 0, bad = 0, sn = 0;
  string quiet_tag = "R8";

  logic [DW-1:0] ref_m [0:(1<<AW)-1];
  logic [DW-1:0] din_s [0:NS-1];
  logic [NB-1:0] bw_s  [0:NS-1];
  logic          ev    [0:NS-1];
  logic [DW-1:0] ed    [0:NS-1];
  string         et    [0:NS-1];

  ddr2b_sram #(.DATA_W(DW), .ADDR_W(AW)) u_ddr2b_sram (
    .clk(clk), .rst(rst), .k_rise(k_rise), .addr(addr), .rd_n(rd_n),
    .wr_n(wr_n), .bw_n(bw_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
    .q_valid(q_valid));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp, input logic oe);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s slot %0d: got dq_o=%h oe=%b valid=%b, expected dq_o=%h",
               tag, sn, got, oe, q_valid, exp);
    end
  endtask

  // one slot: drive at the falling edge, sample after the next rising edge
  task automatic step(input logic rn, input logic wn, input logic [AW-1:0] a);
    k_rise = (sn % 2 == 0);
    rd_n = rn; wr_n = wn; addr = a;
    dq_i = din_s[sn]; bw_n = bw_s[sn];
    @(posedge clk);
    @(negedge clk);
    if (!rst) begin
      if (ev[sn]) chk(dq_oe && q_valid && dq_o == ed[sn], et[sn], dq_o, ed[sn], dq_oe);
      else chk(!dq_oe && !q_valid && dq_o == '0, quiet_tag, dq_o, '0, dq_oe);
    end
    sn++;
  endtask

  task automatic cyc_idle();
    step(1'b1, 1'b1, '0);
    step(1'b1, 1'b1, '0);
  endtask

  task automatic cyc_write(input logic [AW-1:0] a, input logic [DW-1:0] d0,
                           input logic [DW-1:0] d1, input logic [NB-1:0] m0,
                           input logic [NB-1:0] m1);
    logic [AW-1:0] w0, w1;
    w0 = {a[AW-1:1], 1'b0};
    w1 = {a[AW-1:1], 1'b1};
    for (int l = 0; l < NB; l++) begin
      if (!m0[l]) ref_m[w0][l*8 +: 8] = d0[l*8 +: 8];
      if (!m1[l]) ref_m[w1][l*8 +: 8] = d1[l*8 +: 8];
    end
    din_s[sn+2] = d0; bw_s[sn+2] = m0;   // R3: beats two and three slots later
    din_s[sn+3] = d1; bw_s[sn+3] = m1;
    step(1'b1, 1'b0, a);
    step(1'b1, 1'b1, '0);
  endtask

  task automatic cyc_read(input logic [AW-1:0] a, input string tag);
    ev[sn+3] = 1'b1; ed[sn+3] = ref_m[{a[AW-1:1], 1'b0}]; et[sn+3] = tag;
    ev[sn+4] = 1'b1; ed[sn+4] = ref_m[{a[AW-1:1], 1'b1}]; et[sn+4] = tag;
    step(1'b0, 1'b1, a);
    step(1'b1, 1'b1, '0);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin
      din_s[i] = '0; bw_s[i] = '1; ev[i] = 1'b0; ed[i] = '0; et[i] = "";
    end
    for (int i = 0; i < (1 << AW); i++) ref_m[i] = '0;

    // R9: reset state
    repeat (4) step(1'b1, 1'b1, '0);
    rst = 1'b0;
    quiet_tag = "R9";
    cyc_idle();
    quiet_tag = "R8";

    // fill every row with full-width writes
    for (int r = 0; r < (1 << (AW-1)); r++)
      cyc_write(AW'(2*r), 16'(r*16'h0203 + 16'h1000), 16'(r*16'h0405 ^ 16'hBEEF), 2'b00, 2'b00);
    cyc_idle();

    // R4, R6: masked write then back-to-back read of the same row
    for (int i = 0; i < 8; i++) begin
      logic [41:0] v;
      v = VEC[i];
      cyc_write(v[41:36], v[35:20], v[19:4], v[3:2], v[1:0]);
      cyc_read(v[41:36], "R6");
    end
    repeat (3) cyc_idle();

    // R5: odd and even addresses of one row give the same pair
    cyc_read(6'd5, "R5");
    cyc_read(6'd4, "R5");
    cyc_read(6'd63, "R5");
    repeat (3) cyc_idle();

    // R2: continuous reads on every K slot
    cyc_read(6'd10, "R2");
    cyc_read(6'd20, "R2");
    cyc_read(6'd30, "R2");
    cyc_read(6'd40, "R2");
    repeat (3) cyc_idle();

    // R6: row read back from the array while another write sits in the buffer
    cyc_write(6'd12, 16'hAAAA, 16'h5555, 2'b10, 2'b01);
    cyc_write(6'd14, 16'hCAFE, 16'hF00D, 2'b00, 2'b00);
    cyc_read(6'd12, "R6");
    cyc_read(6'd14, "R6");
    repeat (3) cyc_idle();

    // R1: commands in K-bar slots do nothing
    quiet_tag = "R1";
    step(1'b1, 1'b1, '0);
    step(1'b0, 1'b1, 6'd22);
    step(1'b1, 1'b1, '0);
    din_s[sn+2] = 16'hFFFF; bw_s[sn+2] = 2'b00;
    din_s[sn+3] = 16'hFFFF; bw_s[sn+3] = 2'b00;
    step(1'b1, 1'b0, 6'd22);
    repeat (3) cyc_idle();
    cyc_read(6'd22, "R1");
    repeat (3) cyc_idle();

    // R7: both enables low
    quiet_tag = "R7";
    din_s[sn+2] = 16'h7777; bw_s[sn+2] = 2'b00;
    din_s[sn+3] = 16'h7777; bw_s[sn+3] = 2'b00;
    step(1'b0, 1'b0, 6'd24);
    step(1'b1, 1'b1, '0);
    repeat (3) cyc_idle();
    cyc_read(6'd24, "R7");
    repeat (3) cyc_idle();

    // R9: reset drops an in-flight read and an unfinished write
    quiet_tag = "R9";
    step(1'b0, 1'b1, 6'd26);
    rst = 1'b1;
    step(1'b1, 1'b1, '0);
    step(1'b1, 1'b1, '0);
    rst = 1'b0;
    step(1'b1, 1'b1, '0);
    repeat (2) cyc_idle();
    din_s[sn+2] = 16'h0BAD; bw_s[sn+2] = 2'b00;
    din_s[sn+3] = 16'h0BAD; bw_s[sn+3] = 2'b00;
    step(1'b1, 1'b0, 6'd26);
    rst = 1'b1;
    step(1'b1, 1'b1, '0);
    step(1'b1, 1'b1, '0);
    rst = 1'b0;
    step(1'b1, 1'b1, '0);
    repeat (2) cyc_idle();
    cyc_read(6'd26, "R9");
    repeat (3) cyc_idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule